// File: doc/BRIEF.md
# Cartridge Program and Pattern Bank Mapper

This block sits on a console cartridge and turns a handful of CPU register writes into a live bank map. The CPU writes into the upper half of its address space. The block latches a bank-select byte, eight bank values and a two-bit nametable arrangement. From these it translates program addresses into 8 KB bank numbers, and picture-unit pattern addresses into 1 KB bank numbers.

The program window has four 8 KB slots. Two of them hold fixed banks near the end of ROM and two take CPU-chosen banks. Two bits of the select byte reorder the slots. One of them moves the first switchable program bank to the third slot. The other exchanges the 2 KB pattern pairs with the individual 1 KB pattern banks. Every pattern value that is written is doubled before it is stored. A cartridge that carries pattern RAM instead of pattern ROM reports a pattern bank count of zero. In that case pattern writes are dropped and every pattern output is zero. The sizes come in as bank counts, and each output is masked to the ROM it addresses.

Top module: `cart_bank_mapper`

## Requirements
- R1: Register writes are decoded from address bits 15, 14, 13 and 0 only. Bit 15 must be 1. Bits {14,13,0} select the register: 000 is select, 001 is bank data, 010 is mirroring, and every other code is ignored. Bits 12..1 therefore alias, so 0x9FFE acts as the select register and 0x9FFF as the bank data register.
- R2: A select write stores the select byte. A bank data write updates the bank register whose index is held in select bits 2:0.
- R3: Index 0 and index 1 each load a 2 KB pattern pair with the value data×2, which is always even. A pair fills two consecutive slots, holding that value and the value plus one.
- R4: Indices 2 to 5 load four 1 KB pattern banks, each with the value data×2. The value is truncated to the pattern bank width.
- R5: Indices 6 and 7 load program banks A and B. With select bit 6 at 0, program slots 0 to 3 map to A, B, N−2 and N−1, where N is the program bank count.
- R6: With select bit 6 at 1, program slots 0 to 3 map to N−2, B, A and N−1.
- R7: With select bit 7 at 0, pattern slots 0 to 3 hold pair0, pair0+1, pair1 and pair1+1, and slots 4 to 7 hold banks 2 to 5. With select bit 7 at 1, the two groups of four exchange places.
- R8: A mirroring write loads data bits 1:0 onto mirror_o. The encodings are 0 vertical, 1 horizontal, 2 single-screen low and 3 single-screen high. No other write changes mirror_o.
- R9: After reset, program banks A and B are 0 and 1, the pattern registers in index order are 0, 2, 4, 5, 6 and 7, the select byte is 0 and mirror_o is 0.
- R10: When chr_bank_cnt_i is 0, chr_bank_o is 0 and pattern bank writes leave the pattern registers unchanged. When a nonzero count is restored, the outputs show the earlier contents.
- R11: A select write reorders the outputs from the clock edge that stores it. The outputs are combinational from the stored state.
- R12: Each bank number is ANDed with its bank count minus one before it is output. The counts are powers of two, and the program count is at least 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | CPU write strobe, one cycle per write |
| wr_addr_i | input | 16 | CPU write address |
| wr_data_i | input | 8 | CPU write data |
| cpu_addr_i | input | 16 | CPU program read address |
| ppu_addr_i | input | 13 | Picture-unit pattern address |
| prg_bank_cnt_i | input | PRG_BANK_W+1 | Number of 8 KB program banks |
| chr_bank_cnt_i | input | CHR_BANK_W+1 | Number of 1 KB pattern banks, 0 for pattern RAM |
| prg_bank_o | output | PRG_BANK_W | 8 KB bank for cpu_addr_i |
| chr_bank_o | output | CHR_BANK_W | 1 KB bank for ppu_addr_i |
| mirror_o | output | 2 | Nametable arrangement |

## Verification
The assertions assume that both bank counts are powers of two and that the program count is at least 2. They also assume that a write strobe lasts one cycle. The stimulus uses only the counts 16, 32, 128 and 0. It changes a count only while no write is pending, and the write task drops the strobe after a single edge. The sweeps cover all four orderings of the two swap bits, every slot and every register index. They also exercise aliased addresses, the inert register codes and a mid-run switch to pattern RAM and back.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  typedef enum logic [1:0] {
    MIR_VERT   = 2'd0,
    MIR_HORZ   = 2'd1,
    MIR_ONE_LO = 2'd2,
    MIR_ONE_HI = 2'd3
  } mirror_e;

  typedef enum logic [1:0] {
    DEC_NONE,
    DEC_SELECT,
    DEC_DATA,
    DEC_MIRROR
  } dec_e;

  localparam int unsigned PRG_SLOTS    = 4;
  localparam int unsigned CHR_SLOTS    = 8;
  localparam int unsigned CHR_REGS     = 6;
  localparam int unsigned SEL_PRG_SWAP = 6;
  localparam int unsigned SEL_CHR_SWAP = 7;
  localparam logic [2:0]  IDX_PRG_A    = 3'd6;
  localparam logic [2:0]  IDX_PRG_B    = 3'd7;
endpackage

// File: rtl/cbm_regs.sv
module cbm_regs
  import cbm_pkg::*;
#(
  parameter int unsigned PRG_BANK_W = 6,
  parameter int unsigned CHR_BANK_W = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [15:0]                wr_addr_i,
  input  logic [7:0]                 wr_data_i,
  input  logic                       chr_present_i,
  output logic                       prg_swap_o,
  output logic                       chr_swap_o,
  output logic [PRG_BANK_W-1:0]      prg_a_o,
  output logic [PRG_BANK_W-1:0]      prg_b_o,
  output logic [1:0][CHR_BANK_W-1:0] chr_pair_o,
  output logic [3:0][CHR_BANK_W-1:0] chr_one_o,
  output mirror_e                    mirror_o
);
  dec_e                  dec;
  logic [2:0]            idx_q;
  logic                  prg_swap_q, chr_swap_q;
  logic [CHR_BANK_W-1:0] chr_q [CHR_REGS];
  logic [PRG_BANK_W-1:0] prg_a_q, prg_b_q;
  mirror_e               mirror_q;
  logic [CHR_BANK_W-1:0] dbl_data;
  logic [PRG_BANK_W-1:0] prg_data;
  logic                  unused_addr;

  assign unused_addr = ^wr_addr_i[12:1];
  assign dbl_data    = CHR_BANK_W'({wr_data_i, 1'b0});
  assign prg_data    = PRG_BANK_W'(wr_data_i);

  always_comb begin
    dec = DEC_NONE;
    if (wr_en_i && wr_addr_i[15]) begin
      case ({wr_addr_i[14:13], wr_addr_i[0]})
        3'b000:  dec = DEC_SELECT;
        3'b001:  dec = DEC_DATA;
        3'b010:  dec = DEC_MIRROR;
        default: dec = DEC_NONE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q      <= '0;
      prg_swap_q <= 1'b0;
      chr_swap_q <= 1'b0;
      mirror_q   <= MIR_VERT;
    end else begin
      if (dec == DEC_SELECT) begin
        idx_q      <= wr_data_i[2:0];
        prg_swap_q <= wr_data_i[SEL_PRG_SWAP];
        chr_swap_q <= wr_data_i[SEL_CHR_SWAP];
      end
      if (dec == DEC_MIRROR) mirror_q <= mirror_e'(wr_data_i[1:0]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prg_a_q <= PRG_BANK_W'(0);
      prg_b_q <= PRG_BANK_W'(1);
    end else if (dec == DEC_DATA) begin
      if (idx_q == IDX_PRG_A) prg_a_q <= prg_data;
      if (idx_q == IDX_PRG_B) prg_b_q <= prg_data;
    end
  end

  // pattern regs: pairs reset to 0,2; singles to 4..7
  for (genvar g = 0; g < CHR_REGS; g++) begin : g_chr
    localparam int unsigned RST_VAL = (g < 2) ? 2 * g : g + 2;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chr_q[g] <= CHR_BANK_W'(RST_VAL);
      end else if (dec == DEC_DATA && chr_present_i && idx_q == 3'(g)) begin
        chr_q[g] <= dbl_data;
      end
    end
  end

  assign prg_swap_o    = prg_swap_q;
  assign chr_swap_o    = chr_swap_q;
  assign prg_a_o       = prg_a_q;
  assign prg_b_o       = prg_b_q;
  assign chr_pair_o[0] = chr_q[0];
  assign chr_pair_o[1] = chr_q[1];
  assign chr_one_o[0]  = chr_q[2];
  assign chr_one_o[1]  = chr_q[3];
  assign chr_one_o[2]  = chr_q[4];
  assign chr_one_o[3]  = chr_q[5];
  assign mirror_o      = mirror_q;
endmodule

// File: rtl/cbm_prg_map.sv
module cbm_prg_map
  import cbm_pkg::*;
#(
  parameter int unsigned PRG_BANK_W = 6
) (
  input  logic                  swap_i,
  input  logic [PRG_BANK_W-1:0] bank_a_i,
  input  logic [PRG_BANK_W-1:0] bank_b_i,
  input  logic [PRG_BANK_W:0]   bank_cnt_i,
  input  logic [1:0]            slot_i,
  output logic [PRG_BANK_W-1:0] bank_o
);
  logic [PRG_BANK_W:0]   cnt_m1, cnt_m2;
  logic [PRG_BANK_W-1:0] last_bank, second_bank, mask;
  logic [PRG_BANK_W-1:0] tbl [PRG_SLOTS];
  logic                  unused_msb;

  assign cnt_m1      = bank_cnt_i - 1'b1;
  assign cnt_m2      = bank_cnt_i - 2'd2;
  assign last_bank   = cnt_m1[PRG_BANK_W-1:0];
  assign second_bank = cnt_m2[PRG_BANK_W-1:0];
  assign mask        = cnt_m1[PRG_BANK_W-1:0];
  assign unused_msb  = cnt_m1[PRG_BANK_W] ^ cnt_m2[PRG_BANK_W];

  always_comb begin
    tbl[0] = swap_i ? second_bank : bank_a_i;
    tbl[1] = bank_b_i;
    tbl[2] = swap_i ? bank_a_i : second_bank;
    tbl[3] = last_bank;
  end

  assign bank_o = tbl[slot_i] & mask;
endmodule

// File: rtl/cbm_chr_map.sv
module cbm_chr_map
  import cbm_pkg::*;
#(
  parameter int unsigned CHR_BANK_W = 8
) (
  input  logic                       swap_i,
  input  logic [1:0][CHR_BANK_W-1:0] pair_i,
  input  logic [3:0][CHR_BANK_W-1:0] one_i,
  input  logic [CHR_BANK_W:0]        bank_cnt_i,
  input  logic [2:0]                 slot_i,
  output logic [CHR_BANK_W-1:0]      bank_o
);
  localparam int unsigned HALF = CHR_SLOTS / 2;

  logic [CHR_BANK_W:0]   cnt_m1;
  logic [CHR_BANK_W-1:0] mask;
  logic [CHR_BANK_W-1:0] tbl [CHR_SLOTS];
  logic                  unused_msb;

  assign cnt_m1     = bank_cnt_i - 1'b1;
  assign unused_msb = cnt_m1[CHR_BANK_W];
  // zero count means pattern RAM: force every bank to 0
  assign mask       = (bank_cnt_i == '0) ? '0 : cnt_m1[CHR_BANK_W-1:0];

  for (genvar s = 0; s < HALF; s++) begin : g_slot
    logic [CHR_BANK_W-1:0] pair_val, one_val;
    assign pair_val      = pair_i[s/2] + CHR_BANK_W'(s % 2);
    assign one_val       = one_i[s];
    assign tbl[s]        = swap_i ? one_val : pair_val;
    assign tbl[s + HALF] = swap_i ? pair_val : one_val;
  end

  assign bank_o = tbl[slot_i] & mask;
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cbm_pkg::*;
#(
  parameter int unsigned PRG_BANK_W = 6,
  parameter int unsigned CHR_BANK_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [15:0]           wr_addr_i,
  input  logic [7:0]            wr_data_i,
  input  logic [15:0]           cpu_addr_i,
  input  logic [12:0]           ppu_addr_i,
  input  logic [PRG_BANK_W:0]   prg_bank_cnt_i,
  input  logic [CHR_BANK_W:0]   chr_bank_cnt_i,
  output logic [PRG_BANK_W-1:0] prg_bank_o,
  output logic [CHR_BANK_W-1:0] chr_bank_o,
  output logic [1:0]            mirror_o
);
  logic                       prg_swap, chr_swap;
  logic [PRG_BANK_W-1:0]      prg_a, prg_b;
  logic [1:0][CHR_BANK_W-1:0] chr_pair;
  logic [3:0][CHR_BANK_W-1:0] chr_one;
  mirror_e                    mirror;
  logic                       chr_present;
  logic                       unused_cpu, unused_ppu;

  assign chr_present = (chr_bank_cnt_i != '0);
  assign unused_cpu  = ^{cpu_addr_i[15], cpu_addr_i[12:0]};
  assign unused_ppu  = ^ppu_addr_i[9:0];

  cbm_regs #(
    .PRG_BANK_W(PRG_BANK_W),
    .CHR_BANK_W(CHR_BANK_W)
  ) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_data_i    (wr_data_i),
    .chr_present_i(chr_present),
    .prg_swap_o   (prg_swap),
    .chr_swap_o   (chr_swap),
    .prg_a_o      (prg_a),
    .prg_b_o      (prg_b),
    .chr_pair_o   (chr_pair),
    .chr_one_o    (chr_one),
    .mirror_o     (mirror)
  );

  cbm_prg_map #(
    .PRG_BANK_W(PRG_BANK_W)
  ) u_prg_map (
    .swap_i    (prg_swap),
    .bank_a_i  (prg_a),
    .bank_b_i  (prg_b),
    .bank_cnt_i(prg_bank_cnt_i),
    .slot_i    (cpu_addr_i[14:13]),
    .bank_o    (prg_bank_o)
  );

  cbm_chr_map #(
    .CHR_BANK_W(CHR_BANK_W)
  ) u_chr_map (
    .swap_i    (chr_swap),
    .pair_i    (chr_pair),
    .one_i     (chr_one),
    .bank_cnt_i(chr_bank_cnt_i),
    .slot_i    (ppu_addr_i[12:10]),
    .bank_o    (chr_bank_o)
  );

  assign mirror_o = mirror;
endmodule

// File: rtl/cart_bank_mapper_chk.sv
module cart_bank_mapper_chk #(
  parameter int unsigned PRG_BANK_W = 6,
  parameter int unsigned CHR_BANK_W = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  wr_en_i,
  input logic [15:0]           wr_addr_i,
  input logic [7:0]            wr_data_i,
  input logic [15:0]           cpu_addr_i,
  input logic [PRG_BANK_W:0]   prg_bank_cnt_i,
  input logic [CHR_BANK_W:0]   chr_bank_cnt_i,
  input logic [PRG_BANK_W-1:0] prg_bank_o,
  input logic [CHR_BANK_W-1:0] chr_bank_o,
  input logic [1:0]            mirror_o
);
  logic                  mir_wr;
  logic                  prg_pow2;
  logic [PRG_BANK_W-1:0] prg_mask;

  assign mir_wr   = wr_en_i && (wr_addr_i[15:13] == 3'b101) && !wr_addr_i[0];
  assign prg_mask = PRG_BANK_W'(prg_bank_cnt_i - 1'b1);
  assign prg_pow2 = (prg_bank_cnt_i >= 2) &&
                    ((prg_bank_cnt_i & (prg_bank_cnt_i - 1'b1)) == '0);

  assert_mirror_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mir_wr |=> (mirror_o == $past(wr_data_i[1:0])));

  assert_mirror_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mir_wr |=> $stable(mirror_o));

  assert_last_slot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prg_pow2 && cpu_addr_i[15] && cpu_addr_i[14:13] == 2'b11)
      |-> (prg_bank_o == prg_mask));

  assert_prg_mask_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prg_pow2 |-> ((prg_bank_o & ~prg_mask) == '0));

  assert_no_pattern_rom_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chr_bank_cnt_i == '0) |-> (chr_bank_o == '0));
endmodule

bind cart_bank_mapper cart_bank_mapper_chk #(
  .PRG_BANK_W(PRG_BANK_W),
  .CHR_BANK_W(CHR_BANK_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .wr_addr_i     (wr_addr_i),
  .wr_data_i     (wr_data_i),
  .cpu_addr_i    (cpu_addr_i),
  .prg_bank_cnt_i(prg_bank_cnt_i),
  .chr_bank_cnt_i(chr_bank_cnt_i),
  .prg_bank_o    (prg_bank_o),
  .chr_bank_o    (chr_bank_o),
  .mirror_o      (mirror_o)
);

// File: tb/cart_bank_mapper_tb.sv
`timescale 1ns/1ps
module cart_bank_mapper_tb;
  localparam int PW = 6;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [15:0]   wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic [15:0]   cpu_addr = 16'h8000;
  logic [12:0]   ppu_addr = '0;
  logic [PW:0]   prg_cnt = 7'd32;
  logic [CW:0]   chr_cnt = 9'd128;
  logic [PW-1:0] prg_bank;
  logic [CW-1:0] chr_bank;
  logic [1:0]    mirror;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference state
  int m_sel;
  int m_bank [8];
  int m_mir;

  always #2.5 clk = ~clk;

  cart_bank_mapper #(.PRG_BANK_W(PW), .CHR_BANK_W(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .cpu_addr_i(cpu_addr), .ppu_addr_i(ppu_addr),
    .prg_bank_cnt_i(prg_cnt), .chr_bank_cnt_i(chr_cnt),
    .prg_bank_o(prg_bank), .chr_bank_o(chr_bank), .mirror_o(mirror)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_sel = 0;
    m_mir = 0;
    m_bank = '{0, 2, 4, 5, 6, 7, 0, 1};
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a[15]) begin
      case ({a[14:13], a[0]})
        3'b000: m_sel = int'(d);
        3'b001: begin
          int idx = m_sel & 7;
          if (idx >= 6) m_bank[idx] = int'(d);
          else if (chr_cnt != 0) m_bank[idx] = (int'(d) * 2) & 255;
        end
        3'b010: m_mir = int'(d) & 3;
        default: ;
      endcase
    end
  endtask

  function automatic int exp_prg(input int s);
    int n = int'(prg_cnt);
    int a = m_bank[6] & 63;
    int b = m_bank[7] & 63;
    int v;
    bit sw = ((m_sel >> 6) & 1) != 0;
    case (s)
      0: v = sw ? n - 2 : a;
      1: v = b;
      2: v = sw ? a : n - 2;
      default: v = n - 1;
    endcase
    return v & (n - 1) & 63;
  endfunction

  function automatic int exp_chr(input int s);
    int v;
    int half = (s / 4) ^ ((m_sel >> 7) & 1);
    if (chr_cnt == 0) return 0;
    if (half == 0) v = m_bank[(s % 4) / 2] + (s % 2);
    else v = m_bank[2 + (s % 4)];
    return v & 255 & (int'(chr_cnt) - 1);
  endfunction

  task automatic check_all(input string req_p, input string req_c);
    for (int s = 0; s < 4; s++) begin
      cpu_addr = {1'b1, 2'(s), 13'h0155};
      #0.2;
      check(req_p, $sformatf("prg slot %0d", s), int'(prg_bank), exp_prg(s));
    end
    for (int s = 0; s < 8; s++) begin
      ppu_addr = {3'(s), 10'h2a3};
      #0.2;
      check(req_c, $sformatf("chr slot %0d", s), int'(chr_bank), exp_chr(s));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R9 reset state
    check_all("R9", "R9");
    check("R9", "mirror", int'(mirror), 0);

    // R2 R3 R4 R5 R6 R7: all swap orderings, every index
    for (int k = 0; k < 4; k++) begin
      int sel = k << 6;
      for (int i = 0; i < 8; i++) begin
        wr(16'h8000, 8'(sel | i));
        wr(16'h8001, 8'((i * 53 + k * 29 + 7) & 255));
      end
      check_all(k[0] ? "R6" : "R5", k[1] ? "R7" : "R3 R4");
    end
    check_all("R2", "R2");

    // R1 aliased addresses
    wr(16'h9FFE, 8'h03);
    wr(16'h9FFF, 8'hC5);
    check_all("R1", "R1 R4");
    wr(16'h9ABC, 8'h86);
    wr(16'h8E11, 8'h2B);
    check_all("R1", "R1 R7");
    wr(16'h0000, 8'h07);        // bit 15 low: ignored
    wr(16'h7FFF, 8'hFF);
    check_all("R1", "R1");

    // R11: reorder visible right after the storing edge
    wr(16'h8000, 8'h06);
    cpu_addr = 16'h8000; #0.2;
    check("R11", "prg slot0 unswapped", int'(prg_bank), exp_prg(0));
    wr(16'h8000, 8'h46);
    cpu_addr = 16'h8000; #0.2;
    check("R11", "prg slot0 swapped", int'(prg_bank), exp_prg(0));
    wr(16'h8000, 8'hC0);
    ppu_addr = 13'h0000; #0.2;
    check("R11", "chr slot0 swapped", int'(chr_bank), exp_chr(0));

    // R8 mirroring and inert registers
    for (int m = 0; m < 4; m++) begin
      wr(16'hA000, 8'(8'hF0 | m));
      check("R8", "mirror load", int'(mirror), m);
    end
    wr(16'hBFFE, 8'h01);
    check("R8", "mirror alias", int'(mirror), 1);
    wr(16'hA001, 8'h02);
    check("R8", "A001 inert", int'(mirror), 1);
    wr(16'hC000, 8'h03);
    wr(16'hC001, 8'h00);
    wr(16'hE000, 8'h02);
    wr(16'hE001, 8'h47);
    check("R8", "irq regs inert", int'(mirror), 1);
    check_all("R8", "R8");

    // R12 masking with a smaller program ROM
    prg_cnt = 7'd16;
    wr(16'h8000, 8'h06); wr(16'h8001, 8'h3D);
    wr(16'h8000, 8'h07); wr(16'h8001, 8'h2E);
    check_all("R12", "R12");
    wr(16'h8000, 8'h40);
    check_all("R12 R6", "R12");
    prg_cnt = 7'd32;

    // R10 pattern RAM: writes dropped, outputs zero
    do_reset();
    chr_cnt = '0;
    for (int i = 0; i < 6; i++) begin
      wr(16'h8000, 8'(i));
      wr(16'h8001, 8'(8'h11 + i * 8'h22));
    end
    check_all("R10", "R10");
    wr(16'h8000, 8'h80);
    check_all("R10", "R10");
    chr_cnt = 9'd128;
    check_all("R10", "R10 restore");
    wr(16'h8000, 8'h00);
    check_all("R10", "R10 restore");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule